// File: doc/BRIEF.md
# Serial memory page write collector with timed commit

This block sits behind the byte-level decoder of a two-wire serial memory slave. It gathers the data bytes of one write transaction into a 64-entry page buffer. When the transaction closes cleanly, it copies the gathered bytes into a 32K x 8 array as one self-timed program cycle. The decoder hands it a pulse with the 15-bit word address once both address bytes are in. It also sends a pulse for each completed data byte, a pulse for each ACK slot that closes a data byte, and pulses for bus stop and start events. The block drives the array's write port, a busy flag that the decoder uses to stay silent on the bus, and the live address counter.

Address bits 14..6 select one of 512 pages, and bits 5..0 select the byte inside the page. Each acknowledged byte advances only the low six bits, so a long burst circles around the same page. A later byte replaces whatever was buffered at its offset. A commit writes only the offsets that actually received an acknowledged byte, visiting them from offset 0 upward. The programming delay is a cycle count, `WRITE_CYCLES`, so a bench can shorten it. When the protect input is high, the burst is still accepted and counted, but nothing is committed and the block never goes busy.

Top module: `page_write_ctrl`

## Requirements
- R1: An `addr_load` pulse while not busy opens a transaction: page = `addr_in[14:6]`, offset = `addr_in[5:0]`, and `addr_cnt` equals `addr_in` from the next cycle.
- R2: An `ack_stb` that follows a `byte_stb` advances only the 6-bit offset by one, with 63 wrapping to 0 in the same page. An `ack_stb` with no byte waiting has no effect on `addr_cnt`.
- R3: When more than 64 bytes arrive in one transaction, each byte replaces the earlier one at its offset, so the committed value at each offset is the last one acknowledged there.
- R4: A `stop_evt` in an open transaction with at least one acknowledged byte and no unacknowledged byte raises `busy` on the next cycle for exactly `WRITE_CYCLES` cycles. During that time `mem_we` pulses once per loaded offset, in ascending offset order, with `mem_addr` = {page, offset}.
- R5: A `stop_evt` that arrives while a byte waits for its ACK, or before any byte has been acknowledged, discards the transaction: no `mem_we` and no `busy`. A `start_evt` also discards the open transaction, without a write, but keeps the counter.
- R6: When `wp` is high at the stop, no `mem_we` occurs and `busy` stays low, while `addr_cnt` still shows the advanced offset.
- R7: Offsets of the page that received no acknowledged byte in the transaction are never written.
- R8: While `busy` is high, all inputs are ignored: `addr_cnt` holds, and no transaction is opened or committed.
- R9: After reset, `busy` and `mem_we` are 0 and `addr_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_load | input | 1 | Word address complete; `addr_in` valid |
| addr_in | input | 15 | Word address {page, offset} |
| byte_stb | input | 1 | A data byte has been received |
| byte_data | input | 8 | Received data byte |
| ack_stb | input | 1 | ACK slot of the received byte finished |
| stop_evt | input | 1 | Bus stop event |
| start_evt | input | 1 | Bus start event |
| wp | input | 1 | Array protect, active high |
| busy | output | 1 | Program cycle in progress |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | 15 | Array write address |
| mem_wdata | output | 8 | Array write data |
| addr_cnt | output | 15 | Current address counter |

## Verification
The bench targets a burst that starts at offset 62. A design that carried the offset into the page bits would write into the next page and leave `addr_cnt` on the wrong page. A 70-byte burst from offset 32 shows whether late bytes replace early ones; a design that appended or dropped them would commit stale values at offsets 32..37. Stops with a byte still waiting for its ACK, stops right after the address, a repeated start and a protected stop each must leave the array untouched. A design that committed on any stop would show stray writes or a busy window there. Inputs fired during the busy window, and an ACK with no byte waiting, catch a design that lets them move the counter.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  parameter int unsigned PWC_ADDR_W = 15;
  parameter int unsigned PWC_OFF_W  = 6;
  parameter int unsigned PWC_DATA_W = 8;
  parameter int unsigned PWC_WRITE_CYCLES = 1250000; // 5 ms at 250 MHz

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_OPEN = 1'b1
  } phase_t;
endpackage

// File: rtl/pwc_page_buf.sv
module pwc_page_buf #(
  parameter int unsigned OFF_W  = 6,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [OFF_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [OFF_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << OFF_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/pwc_txn_ctrl.sv
module pwc_txn_ctrl
  import pwc_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned OFF_W  = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    busy,
  input  logic                    addr_load,
  input  logic [ADDR_W-1:0]       addr_in,
  input  logic                    byte_stb,
  input  logic                    ack_stb,
  input  logic                    stop_evt,
  input  logic                    start_evt,
  input  logic                    wp,
  output logic [ADDR_W-OFF_W-1:0] page,
  output logic [OFF_W-1:0]        off,
  output logic [(1<<OFF_W)-1:0]   valid,
  output logic                    buf_we,
  output logic                    commit_now
);
  phase_t phase;
  logic   pend;   // byte received, ACK outstanding
  logic   got;    // at least one acknowledged byte
  logic   open_ok;

  assign open_ok    = !busy && (phase == PH_OPEN) && !addr_load;
  assign buf_we     = open_ok && !stop_evt && !start_evt && byte_stb;
  assign commit_now = open_ok && stop_evt && got && !pend && !wp;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      page  <= '0;
      off   <= '0;
      valid <= '0;
      pend  <= 1'b0;
      got   <= 1'b0;
    end else if (!busy) begin
      if (addr_load) begin
        phase <= PH_OPEN;
        page  <= addr_in[ADDR_W-1:OFF_W];
        off   <= addr_in[OFF_W-1:0];
        valid <= '0;
        pend  <= 1'b0;
        got   <= 1'b0;
      end else if (phase == PH_OPEN) begin
        if (stop_evt || start_evt) begin
          phase <= PH_IDLE;
          pend  <= 1'b0;
        end else if (byte_stb) begin
          pend <= 1'b1;
        end else if (ack_stb && pend) begin
          pend       <= 1'b0;
          got        <= 1'b1;
          valid[off] <= 1'b1;
          off        <= off + 1'b1;
        end
      end
    end
  end

  // R2: an accepted ACK moves the offset by exactly one, wrapping in the page
  a_r2_offset_step: assert property (@(posedge clk) disable iff (rst)
    (open_ok && !stop_evt && !start_evt && !byte_stb && ack_stb && pend)
      |=> (off == OFF_W'($past(off) + 1'b1)) && $stable(page));
endmodule

// File: rtl/pwc_commit_timer.sv
module pwc_commit_timer #(
  parameter int unsigned OFF_W        = 6,
  parameter int unsigned WRITE_CYCLES = 1250000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             commit,
  output logic             busy,
  output logic             scan_en,
  output logic [OFF_W-1:0] scan_idx
);
  localparam int unsigned DEPTH = 1 << OFF_W;
  localparam int unsigned CNT_W = $clog2(WRITE_CYCLES + 1);

  logic [CNT_W-1:0] tmr;

  assign scan_en  = busy && (tmr < CNT_W'(DEPTH));
  assign scan_idx = tmr[OFF_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      tmr  <= '0;
    end else if (!busy) begin
      if (commit) begin
        busy <= 1'b1;
        tmr  <= '0;
      end
    end else if (tmr == CNT_W'(WRITE_CYCLES - 1)) begin
      busy <= 1'b0;
    end else begin
      tmr <= tmr + 1'b1;
    end
  end

  // R4: the busy window opens only on a commit request
  a_r4_busy_from_commit: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(commit));
endmodule

// File: rtl/page_write_ctrl.sv
module page_write_ctrl
  import pwc_pkg::*;
#(
  parameter int unsigned ADDR_W       = PWC_ADDR_W,
  parameter int unsigned OFF_W        = PWC_OFF_W,
  parameter int unsigned DATA_W       = PWC_DATA_W,
  parameter int unsigned WRITE_CYCLES = PWC_WRITE_CYCLES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_stb,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              ack_stb,
  input  logic              stop_evt,
  input  logic              start_evt,
  input  logic              wp,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [ADDR_W-1:0] addr_cnt
);
  localparam int unsigned PAGE_W = ADDR_W - OFF_W;
  localparam int unsigned DEPTH  = 1 << OFF_W;

  logic [PAGE_W-1:0] page;
  logic [OFF_W-1:0]  off;
  logic [DEPTH-1:0]  valid;
  logic              buf_we;
  logic              commit_now;
  logic              scan_en;
  logic [OFF_W-1:0]  scan_idx;

  pwc_txn_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ctrl (
    .clk(clk), .rst(rst), .busy(busy),
    .addr_load(addr_load), .addr_in(addr_in),
    .byte_stb(byte_stb), .ack_stb(ack_stb),
    .stop_evt(stop_evt), .start_evt(start_evt), .wp(wp),
    .page(page), .off(off), .valid(valid),
    .buf_we(buf_we), .commit_now(commit_now)
  );

  pwc_page_buf #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .we(buf_we), .waddr(off), .wdata(byte_data),
    .raddr(scan_idx), .rdata(mem_wdata)
  );

  pwc_commit_timer #(.OFF_W(OFF_W), .WRITE_CYCLES(WRITE_CYCLES)) u_tmr (
    .clk(clk), .rst(rst), .commit(commit_now),
    .busy(busy), .scan_en(scan_en), .scan_idx(scan_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we   <= 1'b0;
      mem_addr <= '0;
    end else begin
      mem_we   <= scan_en && valid[scan_idx];
      mem_addr <= {page, scan_idx};
    end
  end

  assign addr_cnt = {page, off};

  // R8: the counter is frozen while a program cycle runs
  a_r8_hold_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(addr_cnt));

  // R4: array writes happen only inside the busy window
  a_r4_we_in_busy: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  // R4: every write lands in the transaction's page
  a_r4_we_same_page: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr[ADDR_W-1:OFF_W] == addr_cnt[ADDR_W-1:OFF_W]));

  // R6: a protected stop never starts a program cycle
  a_r6_wp_no_busy: assert property (@(posedge clk) disable iff (rst)
    (!busy && wp && stop_evt) |=> !busy);

  initial begin
    a_r4_cycles_fit: assert (WRITE_CYCLES > DEPTH);
  end
endmodule

// File: tb/page_write_ctrl_tb.sv
module page_write_ctrl_tb;
  localparam int WC = 100;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        addr_load = 0, byte_stb = 0, ack_stb = 0, stop_evt = 0, start_evt = 0, wp = 0;
  logic [14:0] addr_in = '0;
  logic [7:0]  byte_data = '0;
  logic        busy, mem_we;
  logic [14:0] mem_addr, addr_cnt;
  logic [7:0]  mem_wdata;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk; // 250 MHz

  page_write_ctrl #(.WRITE_CYCLES(WC)) u_dut (
    .clk(clk), .rst(rst), .addr_load(addr_load), .addr_in(addr_in),
    .byte_stb(byte_stb), .byte_data(byte_data), .ack_stb(ack_stb),
    .stop_evt(stop_evt), .start_evt(start_evt), .wp(wp),
    .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .addr_cnt(addr_cnt)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_left, m_page, m_off;
  bit m_open, m_pend, m_got;
  int m_buf[64];
  bit m_val[64];
  int q_addr[$], q_data[$];
  int wr_seen;
  bit busy_seen;
  int seen_mem[int];

  always @(posedge clk) begin
    if (rst) begin
      m_left = 0; m_page = 0; m_off = 0; m_open = 0; m_pend = 0; m_got = 0;
    end else if (m_left > 0) begin
      m_left--;
    end else if (addr_load) begin
      m_open = 1; m_pend = 0; m_got = 0;
      m_page = int'(addr_in) / 64; m_off = int'(addr_in) % 64;
      foreach (m_val[i]) m_val[i] = 0;
    end else if (m_open) begin
      if (stop_evt) begin
        if (m_got && !m_pend && !wp) begin
          m_left = WC;
          for (int i = 0; i < 64; i++)
            if (m_val[i]) begin
              q_addr.push_back(m_page * 64 + i);
              q_data.push_back(m_buf[i]);
            end
        end
        m_open = 0; m_pend = 0;
      end else if (start_evt) begin
        m_open = 0; m_pend = 0;
      end else if (byte_stb) begin
        m_buf[m_off] = int'(byte_data); m_pend = 1;
      end else if (ack_stb && m_pend) begin
        m_val[m_off] = 1; m_pend = 0; m_got = 1;
        m_off = (m_off + 1) % 64;
      end
    end
    #1;
    if (!rst) begin
      check(busy == (m_left > 0), "R4 busy window", int'(busy), int'(m_left > 0));
      check(int'(addr_cnt) == m_page * 64 + m_off, "R2 address counter",
            int'(addr_cnt), m_page * 64 + m_off);
      if (busy) busy_seen = 1;
      if (mem_we) begin
        wr_seen++;
        seen_mem[int'(mem_addr)] = int'(mem_wdata);
        if (q_addr.size() == 0) begin
          check(0, "R7 unexpected write", int'(mem_addr), -1);
        end else begin
          check(int'(mem_addr) == q_addr[0], "R4 write address", int'(mem_addr), q_addr[0]);
          check(int'(mem_wdata) == q_data[0], "R3 write data", int'(mem_wdata), q_data[0]);
          void'(q_addr.pop_front());
          void'(q_data.pop_front());
        end
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic load(input int a);
    @(negedge clk); addr_load = 1; addr_in = 15'(a);
    @(negedge clk); addr_load = 0;
  endtask
  task automatic send_byte(input int d, input bit do_ack);
    @(negedge clk); byte_stb = 1; byte_data = 8'(d);
    @(negedge clk); byte_stb = 0;
    if (do_ack) begin
      @(negedge clk); ack_stb = 1;
      @(negedge clk); ack_stb = 0;
    end
  endtask
  task automatic stop();
    @(negedge clk); stop_evt = 1;
    @(negedge clk); stop_evt = 0;
  endtask
  task automatic settle();
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask
  task automatic begin_case();
    wr_seen = 0; busy_seen = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(busy == 0 && mem_we == 0, "R9 reset outputs", int'({busy, mem_we}), 0);
    check(addr_cnt == 0, "R9 reset counter", int'(addr_cnt), 0);

    // single byte write
    begin_case();
    load(15'h1234);
    check(addr_cnt == 15'h1234, "R1 address load", int'(addr_cnt), 'h1234);
    send_byte('hA5, 1);
    check(addr_cnt == 15'h1235, "R2 offset step", int'(addr_cnt), 'h1235);
    stop(); settle();
    check(wr_seen == 1, "R4 single write count", wr_seen, 1);
    check(seen_mem.exists('h1234) && seen_mem['h1234] == 'hA5, "R4 single write data",
          seen_mem.exists('h1234) ? seen_mem['h1234] : -1, 'hA5);
    check(addr_cnt == 15'h1235, "R4 counter after commit", int'(addr_cnt), 'h1235);

    // burst wrapping at the page end
    begin_case();
    load(5 * 64 + 62);
    for (int i = 0; i < 4; i++) send_byte('h10 + i, 1);
    check(addr_cnt == 15'(5 * 64 + 2), "R2 page wrap", int'(addr_cnt), 5 * 64 + 2);
    stop(); settle();
    check(wr_seen == 4, "R7 only loaded offsets", wr_seen, 4);
    check(seen_mem.exists(5 * 64 + 1) && seen_mem[5 * 64 + 1] == 'h13, "R2 wrapped byte",
          seen_mem.exists(5 * 64 + 1) ? seen_mem[5 * 64 + 1] : -1, 'h13);

    // 70-byte overflow from offset 32
    begin_case();
    load(9 * 64 + 32);
    for (int i = 0; i < 70; i++) send_byte(i, 1);
    check(addr_cnt == 15'(9 * 64 + 38), "R2 counter after overflow", int'(addr_cnt), 9 * 64 + 38);
    stop(); settle();
    check(wr_seen == 64, "R3 full page written", wr_seen, 64);
    check(seen_mem[9 * 64 + 32] == 64, "R3 overwrite offset 32", seen_mem[9 * 64 + 32], 64);
    check(seen_mem[9 * 64 + 37] == 69, "R3 overwrite offset 37", seen_mem[9 * 64 + 37], 69);
    check(seen_mem[9 * 64 + 38] == 6, "R3 untouched second pass", seen_mem[9 * 64 + 38], 6);

    // stop while a byte waits for its ACK
    begin_case();
    load('h0400);
    send_byte('h55, 0);
    stop(); settle();
    check(wr_seen == 0 && !busy_seen, "R5 stop before ack", wr_seen + int'(busy_seen), 0);

    // stop straight after the address
    begin_case();
    load('h0500);
    stop(); settle();
    check(wr_seen == 0 && !busy_seen, "R5 stop without data", wr_seen + int'(busy_seen), 0);

    // repeated start discards
    begin_case();
    load('h0600);
    send_byte(1, 1); send_byte(2, 1);
    @(negedge clk); start_evt = 1; @(negedge clk); start_evt = 0;
    stop(); settle();
    check(wr_seen == 0 && !busy_seen, "R5 start discards", wr_seen + int'(busy_seen), 0);
    check(addr_cnt == 15'h0602, "R5 counter kept", int'(addr_cnt), 'h0602);

    // write protect
    begin_case();
    wp = 1;
    load('h0700);
    for (int i = 0; i < 3; i++) send_byte('h80 + i, 1);
    stop(); settle();
    wp = 0;
    check(wr_seen == 0 && !busy_seen, "R6 protected stop", wr_seen + int'(busy_seen), 0);
    check(addr_cnt == 15'h0703, "R6 counter advances", int'(addr_cnt), 'h0703);

    // ACK with no byte waiting
    begin_case();
    load('h0800);
    @(negedge clk); ack_stb = 1; @(negedge clk); ack_stb = 0;
    check(addr_cnt == 15'h0800, "R2 stray ack ignored", int'(addr_cnt), 'h0800);
    send_byte('h3C, 1);
    stop(); settle();
    check(wr_seen == 1 && seen_mem['h0800] == 'h3C, "R2 write after stray ack",
          seen_mem.exists('h0800) ? seen_mem['h0800] : -1, 'h3C);

    // inputs during busy
    begin_case();
    load('h0900);
    send_byte('h77, 1);
    stop();
    repeat (4) @(negedge clk);
    load('h0A00);
    send_byte('h99, 1);
    stop();
    check(addr_cnt == 15'h0901, "R8 counter frozen", int'(addr_cnt), 'h0901);
    settle();
    check(wr_seen == 1 && !seen_mem.exists('h0A00), "R8 busy inputs ignored", wr_seen, 1);

    check(q_addr.size() == 0, "R4 all expected writes seen", q_addr.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule